// File: doc/BRIEF.md
# Memory-Mapped Region Address Router

This block sits between a processor load/store port and five targets: main RAM, a linear video frame buffer, a local interrupt controller register window, an I/O interrupt controller register window and an external default handler. Each request is decoded in two levels. A coarse test first decides whether the address is special, meaning it lies in the legacy video hole or at or above the installed RAM size. Anything that is not special goes straight to RAM. A special address is then matched against the frame buffer and the two controller windows, and whatever matches none of them goes to the external handler.

The router also does the byte-lane work that 32-bit register windows need. It tracks which 4 KiB frame-buffer pages have been written, in a bitmap that is read and cleared one 64-bit word at a time. It emits a RAM page-modified notice after every RAM write, so that cached decoded code can be invalidated. After a full-width write to either controller window it pulses an interrupt re-check strobe. The targets answer combinationally on the shared target bus, and the router registers each response.

Top module: `mem_region_router`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid`, `pgmod_valid` and `irq_recheck` are 0, and every bitmap word reads zero.
- R2: An address below `cfg_ram_top` and outside [0xA0000, 0xC0000) selects RAM (`tgt_sel` = 5'b00001) with the unchanged address. `tgt_sel` is one-hot with bit0 RAM, bit1 frame buffer, bit2 local controller, bit3 I/O controller and bit4 external. It is all zero when no request is valid.
- R3: A special address is decoded with the frame buffer first, then the local controller window, then the I/O controller window, and otherwise the external handler. The frame buffer and the window targets receive the offset from their window base. RAM and the external handler receive the raw address.
- R4: A byte read from a controller window presents the word-aligned offset (offset with bits 1:0 cleared) and `tgt_size` = 2. It returns bits [8*a+7:8*a] of the target data, where a = addr[1:0].
- R5: A 16-bit read (`req_size` = 1) to a special address outside the frame buffer takes two cycles. The first is a byte read at addr, with `req_ready` low. The second is a byte read at addr+1, with each beat decoded on its own. The result is the first byte in bits 7:0 and the second byte in bits 15:8. A 16-bit read inside the frame buffer is a single access.
- R6: An accepted frame-buffer write sets the dirty bit of the page holding its start address, from the following cycle on. Page p = offset>>12 is bit p%64 of bitmap word p/64, and that word is presented combinationally on `dbm_word` for index `dbm_idx`.
- R7: `dbm_clr` zeroes word `dbm_idx` at the next edge. If a frame-buffer write sets a bit of that same word in the same cycle, that bit ends up set.
- R8: The cycle after an accepted RAM write, `pgmod_valid` pulses once, with `pgmod_addr` equal to the start address and `pgmod_end` equal to the start address plus 1, 2 or 4 bytes for `req_size` 0, 1 or 2.
- R9: A 32-bit write (`req_size` = 2) to a controller window is forwarded to that window with its offset, and `irq_recheck` pulses in the following cycle. A byte or 16-bit write to a window goes to the external handler with the raw address and produces no pulse.
- R10: `rsp_valid` pulses in the cycle after the final beat of a read and only then. `rsp_rdata` is zero-extended to the access width (size 0 is 8 bits, 1 is 16 bits, 2 is 32 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ram_top | input | 32 | Installed RAM size; addresses at or above it are special |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 32 | Load data, zero-extended |
| tgt_sel | output | 5 | One-hot target select |
| tgt_we | output | 1 | Target write enable |
| tgt_size | output | 2 | Access size presented to the target |
| tgt_addr | output | 32 | Raw address or window offset |
| tgt_wdata | output | 32 | Store data to target |
| ram_rdata | input | 32 | RAM read data |
| fb_rdata | input | 32 | Frame-buffer read data |
| lic_rdata | input | 32 | Local controller register data |
| ioic_rdata | input | 32 | I/O controller register data |
| ext_rdata | input | 32 | External handler read data |
| pgmod_valid | output | 1 | RAM page-modified notice |
| pgmod_addr | output | 32 | First byte written |
| pgmod_end | output | 32 | One past the last byte written |
| irq_recheck | output | 1 | Interrupt re-check strobe |
| dbm_idx | input | 5 | Bitmap word index |
| dbm_clr | input | 1 | Clear the indexed bitmap word |
| dbm_word | output | 64 | Indexed bitmap word |

## Verification
A clear of a bitmap word and a frame-buffer write that sets a bit in that same word can land on one clock edge. The bench provokes this by asserting `dbm_clr` for word 0 during a frame-buffer store to page 5, after pages 5 and 9 have already been marked. It then reads word 0 back through the bitmap port and expects only bit 5. A second collision comes from a split 16-bit read that straddles two controller registers: the two beats fetch different aligned words, and the bench checks each beat's offset and lane separately.

// File: rtl/mem_region_router.sv
module mem_region_router #(
  parameter logic [31:0] FB_BASE    = 32'hE000_0000,
  parameter int unsigned VRAM_BYTES = 32'h0080_0000,
  parameter logic [31:0] LIC_BASE   = 32'hFEE0_0000,
  parameter int unsigned LIC_BYTES  = 4096,
  parameter logic [31:0] IOIC_BASE  = 32'hFEC0_0000,
  parameter int unsigned IOIC_BYTES = 4096,
  parameter logic [31:0] HOLE_LO    = 32'h000A_0000,
  parameter logic [31:0] HOLE_HI    = 32'h000C_0000,
  localparam int unsigned PAGES = VRAM_BYTES / 4096,
  localparam int unsigned WORDS = PAGES / 64,
  localparam int IW = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   cfg_ram_top,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [31:0]   req_addr,
  input  logic [31:0]   req_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic [4:0]    tgt_sel,
  output logic          tgt_we,
  output logic [1:0]    tgt_size,
  output logic [31:0]   tgt_addr,
  output logic [31:0]   tgt_wdata,
  input  logic [31:0]   ram_rdata,
  input  logic [31:0]   fb_rdata,
  input  logic [31:0]   lic_rdata,
  input  logic [31:0]   ioic_rdata,
  input  logic [31:0]   ext_rdata,
  output logic          pgmod_valid,
  output logic [31:0]   pgmod_addr,
  output logic [31:0]   pgmod_end,
  output logic          irq_recheck,
  input  logic [IW-1:0] dbm_idx,
  input  logic          dbm_clr,
  output logic [63:0]   dbm_word
);

  function automatic logic in_win(input logic [31:0] a, input logic [31:0] base,
                                  input logic [31:0] bytes);
    return (a >= base) && ((a - base) < bytes);
  endfunction

  function automatic logic is_special(input logic [31:0] a, input logic [31:0] top);
    return ((a >= HOLE_LO) && (a < HOLE_HI)) || (a >= top);
  endfunction

  logic              beat_q;
  logic [7:0]        lo_q;
  logic [WORDS-1:0][63:0] dbm;

  logic        split;
  logic [31:0] beat_addr;
  logic [1:0]  eff_size;
  logic        sp, fb_hit, lic_hit, io_hit, ic_ok, ic_sel, fire;
  logic [31:0] raw, lane_sh, rd_val;
  logic [7:0]  rd_byte;

  assign split = req_valid && !req_write && (req_size == 2'd1)
               && is_special(req_addr, cfg_ram_top)
               && !in_win(req_addr, FB_BASE, VRAM_BYTES);
  assign beat_addr = req_addr + {31'd0, beat_q};
  assign eff_size  = split ? 2'd0 : req_size;

  assign sp      = is_special(beat_addr, cfg_ram_top);
  assign fb_hit  = sp && in_win(beat_addr, FB_BASE, VRAM_BYTES);
  assign lic_hit = sp && !fb_hit && in_win(beat_addr, LIC_BASE, LIC_BYTES);
  assign io_hit  = sp && !fb_hit && !lic_hit && in_win(beat_addr, IOIC_BASE, IOIC_BYTES);
  assign ic_ok   = !req_write || (req_size == 2'd2);

  always_comb begin
    tgt_sel = 5'b00000;
    if (req_valid) begin
      if (!sp)                   tgt_sel = 5'b00001;
      else if (fb_hit)           tgt_sel = 5'b00010;
      else if (lic_hit && ic_ok) tgt_sel = 5'b00100;
      else if (io_hit && ic_ok)  tgt_sel = 5'b01000;
      else                       tgt_sel = 5'b10000;
    end
  end

  assign ic_sel = tgt_sel[2] | tgt_sel[3];

  always_comb begin
    tgt_addr = beat_addr;
    if (tgt_sel[1]) tgt_addr = beat_addr - FB_BASE;
    else if (tgt_sel[2]) tgt_addr = beat_addr - LIC_BASE;
    else if (tgt_sel[3]) tgt_addr = beat_addr - IOIC_BASE;
    if (ic_sel && !req_write && eff_size == 2'd0) tgt_addr[1:0] = 2'b00;
  end

  assign tgt_size  = ic_sel ? 2'd2 : eff_size;
  assign tgt_we    = req_valid && req_write;
  assign tgt_wdata = req_wdata;

  always_comb begin
    raw = ext_rdata;
    if (tgt_sel[0]) raw = ram_rdata;
    else if (tgt_sel[1]) raw = fb_rdata;
    else if (tgt_sel[2]) raw = lic_rdata;
    else if (tgt_sel[3]) raw = ioic_rdata;
  end

  assign lane_sh = raw >> {beat_addr[1:0], 3'b000};

  always_comb begin
    if (ic_sel && eff_size == 2'd0) rd_val = {24'd0, lane_sh[7:0]};
    else begin
      case (eff_size)
        2'd0:    rd_val = {24'd0, raw[7:0]};
        2'd1:    rd_val = {16'd0, raw[15:0]};
        default: rd_val = raw;
      endcase
    end
  end

  assign rd_byte   = rd_val[7:0];
  assign req_ready = !split || beat_q;
  assign fire      = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_q      <= 1'b0;
      lo_q        <= 8'd0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= 32'd0;
      pgmod_valid <= 1'b0;
      pgmod_addr  <= 32'd0;
      pgmod_end   <= 32'd0;
      irq_recheck <= 1'b0;
    end else begin
      beat_q      <= split && !beat_q;
      if (split && !beat_q) lo_q <= rd_byte;
      rsp_valid   <= fire && !req_write;
      if (fire && !req_write)
        rsp_rdata <= split ? {16'd0, rd_byte, lo_q} : rd_val;
      pgmod_valid <= fire && req_write && tgt_sel[0];
      if (fire && req_write && tgt_sel[0]) begin
        pgmod_addr <= beat_addr;
        pgmod_end  <= beat_addr + (32'd1 << eff_size);
      end
      irq_recheck <= fire && req_write && ic_sel;
    end
  end

  logic          fb_set;
  logic [IW-1:0] set_w;
  logic [5:0]    set_b;
  logic [WORDS-1:0] clr_hit, set_hit;

  assign fb_set = fire && req_write && tgt_sel[1];
  assign set_w  = tgt_addr[18 +: IW];
  assign set_b  = tgt_addr[17:12];

  for (genvar w = 0; w < WORDS; w++) begin : g_hit
    assign clr_hit[w] = dbm_clr && (dbm_idx == IW'(w));
    assign set_hit[w] = fb_set && (set_w == IW'(w));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dbm <= '0;
    else begin
      for (int w = 0; w < WORDS; w++) begin
        if (clr_hit[w] || set_hit[w])
          dbm[w] <= (clr_hit[w] ? 64'd0 : dbm[w]) | (set_hit[w] ? (64'd1 << set_b) : 64'd0);
      end
    end
  end

  assign dbm_word = dbm[dbm_idx];

endmodule

module mem_region_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] cfg_ram_top,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [31:0] req_addr,
  input logic [4:0]  tgt_sel,
  input logic [31:0] tgt_addr,
  input logic        rsp_valid,
  input logic        pgmod_valid,
  input logic        irq_recheck
);

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel));

  a_r2_idle_no_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (tgt_sel == 5'b00000));

  a_r2_ram_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr < cfg_ram_top && !(req_addr >= 32'h000A_0000 && req_addr < 32'h000C_0000))
    |-> (tgt_sel == 5'b00001 && tgt_addr == req_addr));

  a_r5_stall_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_ready);

  a_r8_notice_after_ram_write: assert property (@(posedge clk) disable iff (!rst_n)
    pgmod_valid |-> $past(req_valid && req_ready && req_write && tgt_sel[0]));

  a_r9_recheck_after_window_write: assert property (@(posedge clk) disable iff (!rst_n)
    irq_recheck |-> $past(req_valid && req_ready && req_write && req_size == 2'd2
                          && (tgt_sel[2] || tgt_sel[3])));

  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

endmodule

bind mem_region_router mem_region_router_chk chk_i (.*);

// File: tb/mem_region_router_tb.sv
`timescale 1ns/1ps
module mem_region_router_tb_top;
  localparam int IW = 5;
  localparam logic [31:0] FBB = 32'hE000_0000;
  localparam logic [31:0] VB  = 32'h0080_0000;
  localparam logic [31:0] LB  = 32'hFEE0_0000;
  localparam logic [31:0] IB  = 32'hFEC0_0000;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n;
  logic [31:0] ram_top;
  logic req_valid, req_ready, req_write;
  logic [1:0] req_size;
  logic [31:0] req_addr, req_wdata;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [4:0] tgt_sel;
  logic tgt_we;
  logic [1:0] tgt_size;
  logic [31:0] tgt_addr, tgt_wdata;
  logic [31:0] ram_rdata, fb_rdata, lic_rdata, ioic_rdata, ext_rdata;
  logic pgmod_valid;
  logic [31:0] pgmod_addr, pgmod_end;
  logic irq_recheck;
  logic [IW-1:0] dbm_idx;
  logic dbm_clr;
  logic [63:0] dbm_word;

  assign ram_rdata  = 32'h1111_0000 ^ tgt_addr;
  assign fb_rdata   = 32'h2222_0000 ^ tgt_addr;
  assign lic_rdata  = 32'hC3B2_A190 ^ tgt_addr;
  assign ioic_rdata = 32'h7E6D_5C4B ^ tgt_addr;
  assign ext_rdata  = 32'h9988_7766 ^ tgt_addr;

  mem_region_router dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ram_top(ram_top),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_size(tgt_size),
    .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
    .ram_rdata(ram_rdata), .fb_rdata(fb_rdata), .lic_rdata(lic_rdata),
    .ioic_rdata(ioic_rdata), .ext_rdata(ext_rdata),
    .pgmod_valid(pgmod_valid), .pgmod_addr(pgmod_addr), .pgmod_end(pgmod_end),
    .irq_recheck(irq_recheck), .dbm_idx(dbm_idx), .dbm_clr(dbm_clr), .dbm_word(dbm_word)
  );

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [63:0] dmodel [32];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic bit f_special(input logic [31:0] a);
    return (a >= 32'h000A_0000 && a < 32'h000C_0000) || a >= ram_top;
  endfunction

  function automatic bit f_fb(input logic [31:0] a);
    return a >= FBB && (a - FBB) < VB;
  endfunction

  function automatic int f_tgt(input logic [31:0] a, input bit we, input logic [1:0] sz);
    if (!f_special(a)) return 0;
    if (f_fb(a)) return 1;
    if (a >= LB && a - LB < 4096) return (we && sz != 2) ? 4 : 2;
    if (a >= IB && a - IB < 4096) return (we && sz != 2) ? 4 : 3;
    return 4;
  endfunction

  function automatic logic [31:0] f_off(input int t, input logic [31:0] a, input bit we, input logic [1:0] sz);
    logic [31:0] o;
    case (t)
      1: o = a - FBB;
      2: o = a - LB;
      3: o = a - IB;
      default: o = a;
    endcase
    if ((t == 2 || t == 3) && !we && sz == 0) o = o & 32'hFFFF_FFFC;
    return o;
  endfunction

  function automatic logic [31:0] f_val(input int t, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] off);
    logic [31:0] r;
    case (t)
      0: r = 32'h1111_0000 ^ off;
      1: r = 32'h2222_0000 ^ off;
      2: r = 32'hC3B2_A190 ^ off;
      3: r = 32'h7E6D_5C4B ^ off;
      default: r = 32'h9988_7766 ^ off;
    endcase
    if ((t == 2 || t == 3) && sz == 0) return (r >> (8 * a[1:0])) & 32'hFF;
    if (sz == 0) return r & 32'hFF;
    if (sz == 1) return r & 32'hFFFF;
    return r;
  endfunction

  task automatic access(input bit we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, input string tag,
                        input bit clr = 1'b0, input int cidx = 0);
    logic [31:0] got;
    bit split;
    int n, t0;
    logic [31:0] ea;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_size = sz; req_addr = a; req_wdata = wd;
    dbm_clr = clr; dbm_idx = IW'(cidx);
    split = !we && sz == 1 && f_special(a) && !f_fb(a);
    n = split ? 2 : 1;
    got = '0;
    for (int b = 0; b < n; b++) begin
      logic [31:0] ba, off;
      logic [1:0] bs;
      int t;
      ba = a + b;
      bs = split ? 2'd0 : sz;
      t = f_tgt(ba, we, bs);
      off = f_off(t, ba, we, bs);
      #1;
      chk(tgt_sel == (5'b00001 << t), {tag, " target select"}, 64'(tgt_sel), 64'(5'b00001 << t));
      chk(tgt_addr == off, {tag, " target address"}, 64'(tgt_addr), 64'(off));
      chk(tgt_we == we, {tag, " write enable"}, 64'(tgt_we), 64'(we));
      chk(req_ready == (b == n - 1), {tag, " ready"}, 64'(req_ready), 64'(b == n - 1));
      if ((t == 2 || t == 3) && !we && bs == 0)
        chk(tgt_size == 2'd2, {tag, " R4 window fetch size"}, 64'(tgt_size), 64'd2);
      got = got | (f_val(t, ba, bs, off) << (8 * b));
      if (b < n - 1) @(negedge clk);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    dbm_clr = 1'b0;
    t0 = f_tgt(a, we, sz);
    chk(rsp_valid == !we, {tag, " R10 response pulse"}, 64'(rsp_valid), 64'(!we));
    if (!we) chk(rsp_rdata == got, {tag, " R10 read data"}, 64'(rsp_rdata), 64'(got));
    chk(pgmod_valid == (we && t0 == 0), {tag, " R8 notice"}, 64'(pgmod_valid), 64'(we && t0 == 0));
    if (we && t0 == 0) begin
      ea = a + (32'd1 << sz);
      chk(pgmod_addr == a, {tag, " R8 notice start"}, 64'(pgmod_addr), 64'(a));
      chk(pgmod_end == ea, {tag, " R8 notice end"}, 64'(pgmod_end), 64'(ea));
    end
    chk(irq_recheck == (we && (t0 == 2 || t0 == 3)), {tag, " R9 recheck"},
        64'(irq_recheck), 64'(we && (t0 == 2 || t0 == 3)));
    if (clr) dmodel[cidx] = '0;
    if (we && t0 == 1) dmodel[(a - FBB) >> 18][((a - FBB) >> 12) & 63] = 1'b1;
  endtask

  task automatic dcheck(input int idx, input string tag);
    @(negedge clk);
    dbm_idx = IW'(idx);
    #1;
    chk(dbm_word == dmodel[idx], tag, dbm_word, dmodel[idx]);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) dmodel[i] = '0;
    rst_n = 1'b0; ram_top = 32'h0800_0000;
    req_valid = 1'b0; req_write = 1'b0; req_size = 2'd0; req_addr = '0; req_wdata = '0;
    dbm_idx = '0; dbm_clr = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
    chk(rsp_valid == 1'b0, "R1 no response after reset", 64'(rsp_valid), 64'd0);
    chk(pgmod_valid == 1'b0, "R1 no notice after reset", 64'(pgmod_valid), 64'd0);
    chk(irq_recheck == 1'b0, "R1 no recheck after reset", 64'(irq_recheck), 64'd0);
    for (int i = 0; i < 32; i++) dcheck(i, "R1 bitmap clear");

    access(0, 2, 32'h0000_1000, 0, "R2 ram word read");
    access(0, 0, 32'h0000_2003, 0, "R2 ram byte read");
    access(0, 0, 32'h0009_FFFF, 0, "R2 below hole");
    access(0, 2, 32'h000C_0000, 0, "R2 above hole");

    access(1, 1, 32'h0000_3002, 32'hABCD, "R8 ram half write");
    access(1, 2, 32'h0000_0010, 32'h1234_5678, "R8 ram word write");
    access(1, 0, 32'h07FF_FFFF, 32'h55, "R8 ram last byte");

    access(0, 2, 32'h000A_0010, 0, "R3 hole to external");
    access(0, 2, 32'h0900_0000, 0, "R3 above ram top to external");
    access(0, 2, FBB + 32'h1234, 0, "R3 frame buffer offset");
    access(0, 2, LB + 32'h40, 0, "R3 local window word");
    access(0, 2, IB + 32'h10, 0, "R3 io window word");
    access(0, 2, FBB + VB, 0, "R3 past frame buffer to external");

    access(0, 0, LB + 32'h22, 0, "R4 local lane 2");
    access(0, 0, IB + 32'h13, 0, "R4 io lane 3");
    access(0, 0, LB + 32'h100, 0, "R4 local lane 0");

    access(0, 1, 32'h000A_0011, 0, "R5 split external half");
    access(0, 1, IB + 32'h13, 0, "R5 split across window words");
    access(0, 1, FBB + 32'h101, 0, "R5 frame buffer half single");
    access(0, 0, FBB + 32'h7, 0, "R10 frame buffer byte mask");

    access(1, 0, FBB + 32'h5000, 32'h1, "R6 dirty page 5");
    dcheck(0, "R6 bitmap word 0");
    access(1, 2, FBB + ((64 * 3 + 7) << 12), 32'h2, "R6 dirty page 199");
    dcheck(3, "R6 bitmap word 3");
    access(1, 0, FBB + 32'h9000, 32'h3, "R6 dirty page 9");
    dcheck(0, "R6 bitmap word 0 two pages");

    access(1, 0, FBB + 32'h5001, 32'h4, "R7 clear with set", 1'b1, 0);
    dcheck(0, "R7 set wins over clear");
    access(0, 2, 32'h0000_0100, 0, "R7 clear alone", 1'b1, 3);
    dcheck(3, "R7 word cleared");

    access(1, 2, IB + 32'h10, 32'h0000_0031, "R9 io window write");
    access(1, 2, LB + 32'h300, 32'h0000_00FF, "R9 local window write");
    access(1, 0, LB + 32'h4, 32'h7, "R9 narrow window write to external");
    access(1, 1, IB + 32'h20, 32'h7, "R9 half window write to external");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule